// File: doc/BRIEF.md
# Protected Page Translation Cache

This block is a small fully associative cache of page translations that sits between a processor's address path and its memory. Each lookup splits a 32-bit virtual address into a 20-bit page number and a 12-bit page offset. It compares the page number against every stored tag in parallel. On a match it returns, in the same cycle, the translated physical address, made from the stored physical page number joined to the untouched offset. It also judges the access against the rights stored with that translation: a supervisor-only flag, read permission and write permission.

When no stored tag matches, the block raises a miss and presents the page number that failed, so that an external table walker can fetch the translation and write it back through the refill port. When the tag matches but the access breaks the stored rights, the block reports a protection fault instead of a usable address. A permitted write marks the entry dirty. Victims for refill are chosen by a least-recently-used policy kept as per-entry ages. A single control clears every translation at once.

Top module: `tlb_perm`

## Requirements
- R1: A lookup whose page number (vaddr bits 31:12) equals the tag of a valid entry raises lk_hit in the same cycle. When no fault is raised, lk_paddr is that entry's physical page number in bits 31:12 and vaddr bits 11:0 in bits 11:0.
- R2: A lookup that matches no valid entry raises lk_miss with miss_vpn equal to the looked-up page number. It holds lk_hit low and lk_paddr at zero, and it changes no stored state.
- R3: A hit faults (lk_fault high) when a supervisor-only entry is used with lk_super low, when a read (lk_write low) hits an entry without read permission, or when a write (lk_write high) hits an entry without write permission.
- R4: A faulting hit drives lk_paddr to zero and changes no stored state: no dirty bit is set and no age is updated.
- R5: A permitted write hit sets the entry's dirty bit, and lk_dirty shows it from the next cycle. lk_dirty shows the hit entry's dirty bit and is zero without a hit.
- R6: A refill overwrites the entry whose tag equals the refill page number if one exists. Otherwise it fills the lowest-numbered invalid entry, and otherwise the least recently used entry. The new contents, including the dirty bit, are visible from the next cycle.
- R7: Every refill and every permitted hit makes its entry the most recently used; the entry used longest ago is the one evicted.
- R8: inv_all clears every valid bit in one cycle and takes priority over a refill in the same cycle.
- R9: After reset every lookup misses.
- R10: While lk_valid is low, lk_hit, lk_miss and lk_fault are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_super | input | 1 | Access made in supervisor mode |
| lk_hit | output | 1 | Tag matched a valid entry |
| lk_miss | output | 1 | No valid entry matched |
| lk_fault | output | 1 | Matched entry forbids this access |
| lk_dirty | output | 1 | Dirty bit of the matched entry |
| lk_paddr | output | 32 | Translated physical address, zero unless a permitted hit |
| miss_vpn | output | 20 | Page number that missed, zero otherwise |
| rf_valid | input | 1 | Write a refill entry this cycle |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_ppn | input | 20 | Refill physical page number |
| rf_sup_only | input | 1 | Refill entry usable only in supervisor mode |
| rf_can_rd | input | 1 | Refill entry allows reads |
| rf_can_wr | input | 1 | Refill entry allows writes |
| rf_dirty | input | 1 | Initial dirty bit of the refill entry |
| inv_all | input | 1 | Invalidate all entries |

## Verification
Hit, miss, fault, dirty, physical address and missing page number are combinational in the lookup inputs and the stored state. The bench therefore drives each lookup just after a falling edge and samples these outputs a quarter period later, in the same cycle. Refills, invalidation, dirty marking and age updates land on the next rising edge, so their effects are checked only by a lookup issued in a later cycle. For replacement order, the bench sequences refills and hits and then probes which page number misses. It never reads the ages themselves.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int TLB_ENTRIES = 8;
  parameter int TLB_VPN_W   = 20;
  parameter int TLB_PPN_W   = 20;
  parameter int TLB_OFF_W   = 12;

  typedef struct packed {
    logic sup_only;
    logic can_rd;
    logic can_wr;
  } tlb_rights_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]              key_i,
  output logic [ENTRIES-1:0]            match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int ENTRIES = 8,
  localparam int AGE_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_i,
  input  logic [AGE_W-1:0]   touch_idx_i,
  output logic [AGE_W-1:0]   lru_idx_o,
  output logic [ENTRIES-1:0] oldest_o
);
  // age 0 = most recent; ages always form a permutation of 0..ENTRIES-1
  logic [ENTRIES-1:0][AGE_W-1:0] age_q;
  logic [AGE_W-1:0]              touched_age;

  assign touched_age = age_q[touch_idx_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= AGE_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (AGE_W'(i) == touch_idx_i)   age_q[i] <= '0;
        else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign oldest_o[g] = (age_q[g] == AGE_W'(ENTRIES-1));
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (oldest_o[i]) lru_idx_o = AGE_W'(i);
  end
endmodule

// File: rtl/tlb_rights.sv
module tlb_rights (
  input  tlb_pkg::tlb_rights_t rights_i,
  input  logic                 is_write_i,
  input  logic                 is_super_i,
  output logic                 fault_o
);
  logic priv_bad, read_bad, write_bad;
  assign priv_bad  = rights_i.sup_only && !is_super_i;
  assign read_bad  = !is_write_i && !rights_i.can_rd;
  assign write_bad = is_write_i && !rights_i.can_wr;
  assign fault_o   = priv_bad || read_bad || write_bad;
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm #(
  parameter int ENTRIES = tlb_pkg::TLB_ENTRIES,
  parameter int VPN_W   = tlb_pkg::TLB_VPN_W,
  parameter int PPN_W   = tlb_pkg::TLB_PPN_W,
  parameter int OFF_W   = tlb_pkg::TLB_OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input  logic             lk_write,
  input  logic             lk_super,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_fault,
  output logic             lk_dirty,
  output logic [PPN_W+OFF_W-1:0] lk_paddr,
  output logic [VPN_W-1:0] miss_vpn,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic             rf_sup_only,
  input  logic             rf_can_rd,
  input  logic             rf_can_wr,
  input  logic             rf_dirty,
  input  logic             inv_all
);
  import tlb_pkg::*;

  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  // index of the single set bit (zero when none)
  function automatic logic [IDX_W-1:0] onehot_idx(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r = '0;
    for (int i = 0; i < ENTRIES; i++) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  // lowest-numbered clear bit
  function automatic logic [IDX_W-1:0] first_clear(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r = '0;
    for (int i = ENTRIES-1; i >= 0; i--) if (!v[i]) r = IDX_W'(i);
    return r;
  endfunction

  // refill target: same tag, else lowest invalid, else least recently used
  function automatic logic [IDX_W-1:0] pick_victim(input logic [ENTRIES-1:0] same_tag,
                                                   input logic [ENTRIES-1:0] valid,
                                                   input logic [IDX_W-1:0]   lru);
    if (|same_tag)  return onehot_idx(same_tag);
    if (!(&valid))  return first_clear(valid);
    return lru;
  endfunction

  // entry storage
  logic [ENTRIES-1:0]            valid_q, dirty_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  tlb_rights_t                   rights_q [ENTRIES];

  // lookup path
  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] tag_match, hit_vec;
  logic [IDX_W-1:0]   hit_idx;
  logic               hit_any, rights_bad, lk_ok;

  assign lk_vpn  = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off  = lk_vaddr[OFF_W-1:0];

  tlb_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_lk_match (
    .valid_i(valid_q), .tags_i(tag_q), .key_i(lk_vpn), .match_o(tag_match)
  );

  assign hit_vec = tag_match & {ENTRIES{lk_valid}};
  assign hit_any = |hit_vec;
  assign hit_idx = onehot_idx(hit_vec);

  tlb_rights u_rights (
    .rights_i(rights_q[hit_idx]), .is_write_i(lk_write),
    .is_super_i(lk_super), .fault_o(rights_bad)
  );

  assign lk_ok    = hit_any && !rights_bad;
  assign lk_hit   = hit_any;
  assign lk_fault = hit_any && rights_bad;
  assign lk_miss  = lk_valid && !hit_any;
  assign lk_dirty = hit_any && dirty_q[hit_idx];
  assign lk_paddr = lk_ok ? {ppn_q[hit_idx], lk_off} : '0;
  assign miss_vpn = lk_miss ? lk_vpn : '0;

  // refill path
  logic [ENTRIES-1:0] rf_same;
  logic [IDX_W-1:0]   lru_idx, victim_idx;
  logic [ENTRIES-1:0] oldest_vec;

  tlb_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_rf_match (
    .valid_i(valid_q), .tags_i(tag_q), .key_i(rf_vpn), .match_o(rf_same)
  );

  assign victim_idx = pick_victim(rf_same, valid_q, lru_idx);

  // named events for the checker
  logic ev_refill, ev_dirty_set, touch_en;
  logic [IDX_W-1:0] touch_idx;

  assign ev_refill    = rf_valid && !inv_all;
  assign ev_dirty_set = lk_ok && lk_write && !rf_valid && !inv_all;
  assign touch_en     = ev_refill || (lk_ok && !inv_all && !rf_valid);
  assign touch_idx    = rf_valid ? victim_idx : hit_idx;

  tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_i(touch_en), .touch_idx_i(touch_idx),
    .lru_idx_o(lru_idx), .oldest_o(oldest_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      tag_q   <= '0;
      ppn_q   <= '0;
      for (int i = 0; i < ENTRIES; i++) rights_q[i] <= '0;
    end else if (inv_all) begin
      valid_q <= '0;
    end else if (ev_refill) begin
      valid_q[victim_idx]  <= 1'b1;
      dirty_q[victim_idx]  <= rf_dirty;
      tag_q[victim_idx]    <= rf_vpn;
      ppn_q[victim_idx]    <= rf_ppn;
      rights_q[victim_idx] <= '{sup_only: rf_sup_only, can_rd: rf_can_rd, can_wr: rf_can_wr};
    end else if (ev_dirty_set) begin
      dirty_q[hit_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input logic                   lk_hit,
  input logic                   lk_miss,
  input logic                   lk_fault,
  input logic [PPN_W+OFF_W-1:0] lk_paddr,
  input logic [VPN_W-1:0]       miss_vpn,
  input logic                   inv_all,
  input logic [ENTRIES-1:0]     hit_vec,
  input logic [ENTRIES-1:0]     valid_q,
  input logic [ENTRIES-1:0]     dirty_q,
  input logic [ENTRIES-1:0]     oldest_vec,
  input logic                   ev_dirty_set
);
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !lk_fault) |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

  a_r2_miss_reports_vpn: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (!lk_hit && miss_vpn == lk_vaddr[VPN_W+OFF_W-1:OFF_W] && lk_paddr == '0));

  a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_hit && lk_paddr == '0));

  a_r5_dirty_marked: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dirty_set |=> ((dirty_q & $past(hit_vec)) == $past(hit_vec)));

  a_r6_unique_tags: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r7_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

  a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
endmodule

bind tlb_perm tlb_perm_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
  .miss_vpn(miss_vpn), .inv_all(inv_all), .hit_vec(hit_vec), .valid_q(valid_q),
  .dirty_q(dirty_q), .oldest_vec(oldest_vec), .ev_dirty_set(ev_dirty_set)
);

// File: tb/tb_tlb_perm.sv
module tb_tlb_perm;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0, lk_super = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss, lk_fault, lk_dirty;
  logic [31:0] lk_paddr;
  logic [19:0] miss_vpn;
  logic        rf_valid = 1'b0, rf_sup_only = 1'b0, rf_can_rd = 1'b0;
  logic        rf_can_wr = 1'b0, rf_dirty = 1'b0, inv_all = 1'b0;
  logic [19:0] rf_vpn = '0, rf_ppn = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_perm dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_super(lk_super), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_fault(lk_fault), .lk_dirty(lk_dirty), .lk_paddr(lk_paddr), .miss_vpn(miss_vpn),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_sup_only(rf_sup_only),
    .rf_can_rd(rf_can_rd), .rf_can_wr(rf_can_wr), .rf_dirty(rf_dirty), .inv_all(inv_all)
  );

  // vector: op[63:62] (0 lookup, 1 refill, 2 invalidate), vpn[61:42], ppn[41:22],
  // rights[21:18] {sup_only,rd,wr,dirty}, access[17:16] {write,super}, off[15:4],
  // expected[3:0] {hit,miss,fault,dirty}; for lookups ppn is the expected page
  localparam int NVEC = 20;
  localparam logic [63:0] VEC [0:NVEC-1] = '{
    {2'd1, 20'h00010, 20'h0A000, 4'b0110, 2'b00, 12'h000, 4'b0000},
    {2'd0, 20'h00010, 20'h0A000, 4'b0000, 2'b00, 12'h123, 4'b1000}, // R1
    {2'd0, 20'h00010, 20'h0A000, 4'b0000, 2'b10, 12'h456, 4'b1000}, // R5 write
    {2'd0, 20'h00010, 20'h0A000, 4'b0000, 2'b00, 12'h789, 4'b1001}, // R5 seen
    {2'd0, 20'h00020, 20'h00000, 4'b0000, 2'b00, 12'h010, 4'b0100}, // R2
    {2'd1, 20'h00020, 20'h0B000, 4'b1100, 2'b00, 12'h000, 4'b0000},
    {2'd0, 20'h00020, 20'h00000, 4'b0000, 2'b00, 12'h020, 4'b1010}, // R3 user
    {2'd0, 20'h00020, 20'h0B000, 4'b0000, 2'b01, 12'hABC, 4'b1000}, // R3 sup ok
    {2'd0, 20'h00020, 20'h00000, 4'b0000, 2'b11, 12'h030, 4'b1010}, // R3 no wr
    {2'd0, 20'h00020, 20'h0B000, 4'b0000, 2'b01, 12'h040, 4'b1000}, // R4 clean
    {2'd1, 20'h00030, 20'h0C000, 4'b0010, 2'b00, 12'h000, 4'b0000},
    {2'd0, 20'h00030, 20'h00000, 4'b0000, 2'b00, 12'h050, 4'b1010}, // R3 no rd
    {2'd0, 20'h00030, 20'h0C000, 4'b0000, 2'b10, 12'h001, 4'b1000}, // R3 wr ok
    {2'd0, 20'h00030, 20'h00000, 4'b0000, 2'b01, 12'h060, 4'b1011}, // R5 on fault
    {2'd1, 20'h00010, 20'h0D000, 4'b0110, 2'b00, 12'h000, 4'b0000},
    {2'd0, 20'h00010, 20'h0D000, 4'b0000, 2'b00, 12'hFFF, 4'b1000}, // R6 overwrite
    {2'd0, 20'h00020, 20'h0B000, 4'b0000, 2'b01, 12'h070, 4'b1000}, // R6 others kept
    {2'd2, 20'h00000, 20'h00000, 4'b0000, 2'b00, 12'h000, 4'b0000},
    {2'd0, 20'h00010, 20'h00000, 4'b0000, 2'b00, 12'h080, 4'b0100}, // R8
    {2'd0, 20'h00030, 20'h00000, 4'b0000, 2'b00, 12'h090, 4'b0100}  // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    lk_valid = 1'b0; rf_valid = 1'b0; inv_all = 1'b0;
  endtask

  task automatic do_lookup(input logic [19:0] vpn, input logic [11:0] off,
                           input logic wr, input logic sup);
    @(negedge clk);
    go_idle();
    lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_write = wr; lk_super = sup;
    #(CLK_PERIOD/4);
  endtask

  task automatic do_refill(input logic [19:0] vpn, input logic [19:0] ppn,
                           input logic [3:0] rights, input logic with_inv);
    @(negedge clk);
    go_idle();
    rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn;
    {rf_sup_only, rf_can_rd, rf_can_wr, rf_dirty} = rights;
    inv_all = with_inv;
  endtask

  task automatic do_inval();
    @(negedge clk);
    go_idle();
    inv_all = 1'b1;
  endtask

  // sampled outputs against the values the requirements give
  task automatic expect_lk(input logic [19:0] vpn, input logic [11:0] off,
                           input logic [19:0] ppn, input logic [3:0] e);
    logic [31:0] exp_pa;
    exp_pa = (e[3] && !e[1]) ? {ppn, off} : 32'h0;
    check("R1 hit", {31'b0, lk_hit}, {31'b0, e[3]});
    check("R2 miss", {31'b0, lk_miss}, {31'b0, e[2]});
    check("R3 fault", {31'b0, lk_fault}, {31'b0, e[1]});
    check("R5 dirty", {31'b0, lk_dirty}, {31'b0, e[0]});
    check("R1 R4 paddr", lk_paddr, exp_pa);
    check("R2 miss_vpn", {12'b0, miss_vpn}, {12'b0, e[2] ? vpn : 20'h0});
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #(CLK_PERIOD/4);
    // R10: no lookup, no flags
    check("R10 idle flags", {29'b0, lk_hit, lk_miss, lk_fault}, 32'h0);
    // R9: empty after reset
    do_lookup(20'h00010, 12'h000, 1'b0, 1'b0);
    expect_lk(20'h00010, 12'h000, 20'h0, 4'b0100);
    do_lookup(20'h00000, 12'h000, 1'b0, 1'b1);
    check("R9 zero page misses", {31'b0, lk_miss}, 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] v;
      v = VEC[i];
      case (v[63:62])
        2'd1: do_refill(v[61:42], v[41:22], v[21:18], 1'b0);
        2'd2: do_inval();
        default: begin
          do_lookup(v[61:42], v[15:4], v[17], v[16]);
          expect_lk(v[61:42], v[15:4], v[41:22], v[3:0]);
        end
      endcase
    end

    // R8: invalidate beats refill in the same cycle
    do_refill(20'h00077, 20'h00177, 4'b0110, 1'b1);
    do_lookup(20'h00077, 12'h000, 1'b0, 1'b0);
    check("R8 inv over refill", {31'b0, lk_miss}, 32'h1);

    // R6/R7: fill all eight, touch the first, then refill twice
    for (int i = 0; i < 8; i++)
      do_refill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 4'b0110, 1'b0);
    do_lookup(20'h00100, 12'h000, 1'b0, 1'b0);
    check("R7 touch first", {31'b0, lk_hit}, 32'h1);
    do_refill(20'h001FF, 20'h002FF, 4'b0110, 1'b0);
    do_lookup(20'h00101, 12'h004, 1'b0, 1'b0);
    check("R7 oldest evicted", {31'b0, lk_miss}, 32'h1);
    do_lookup(20'h00100, 12'h004, 1'b0, 1'b0);
    check("R7 touched kept", lk_paddr, 32'h00200004);
    do_lookup(20'h001FF, 12'h008, 1'b0, 1'b0);
    check("R6 new entry", lk_paddr, 32'h002FF008);
    do_lookup(20'h00102, 12'h00C, 1'b0, 1'b0);
    check("R6 neighbour kept", lk_paddr, 32'h0020200C);
    do_refill(20'h001FE, 20'h002FE, 4'b0110, 1'b0);
    do_lookup(20'h00103, 12'h000, 1'b0, 1'b0);
    check("R7 next oldest evicted", {31'b0, lk_miss}, 32'h1);
    do_lookup(20'h00104, 12'h000, 1'b0, 1'b0);
    check("R7 younger kept", {31'b0, lk_hit}, 32'h1);
    do_lookup(20'h001FE, 12'h010, 1'b0, 1'b0);
    check("R6 second new entry", lk_paddr, 32'h002FE010);

    @(negedge clk);
    go_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule